// File: doc/BRIEF.md
# Enable-Gated Address Window Decoder

This block holds the programming for three address windows: two MMIO windows whose size comes from a mask register, and one register window whose size is fixed at 4 KiB. Software reaches the configuration through a 64-bit register port that accepts only full, aligned 8-byte accesses. Each stored value is trimmed to the bits that matter for its register. The effective base of a window is its register value shifted right by 14.

Setting a window's enable bit takes a snapshot of that window's base and size. From then on, incoming system addresses are compared against the snapshot. A lookup returns, one cycle later, a one-hot hit vector and the offset of the address inside the winning window. Fixed priority resolves overlaps.

A separate error pulse marks accesses that the block does not honour:
- a partial or misaligned access,
- a write to an undefined register,
- a write to the base or mask of a window that is currently enabled. This write is still stored, but it has no effect on decoding until the window is disabled and enabled again.

Top module: `bar_window_dec`

## Requirements
- R1: The register index is the byte address bits [7:3]. An access is legal only with byte address bits [2:0] zero and all eight byte enables set. An illegal access raises `reg_err_o` in the following cycle and modifies no register.
- R2: Register indices 0 (MMIO0 base), 1 (MMIO1 base), 2 (MMIO0 mask) and 3 (MMIO1 mask) store only write-data bits 63:30 and read back with bits 29:0 zero.
- R3: Register index 4 (register-window base) stores only bits 63:26.
- R4: Register index 5 (enable) stores only bits 63:59. Bit 63 enables MMIO0, bit 62 enables MMIO1 and bit 61 enables the register window.
- R5: After reset the registers hold these values:
  - MMIO0 base: 0x3d00000000000<<14
  - MMIO1 base: 0x3ff8000000000<<14
  - MMIO0 mask: 0x3fff000000000<<14
  - MMIO1 mask: 0x3ffff80000000<<14
  - register-window base: 0x3fffe40000000<<14
  - enable: 0
- R6: For an MMIO window, base = register>>14 and size = (~mask>>14)+1. The window hits when base <= addr < base+size, and the offset is addr-base.
- R7: The register window has base = register>>14 and a fixed size of 0x1000 bytes.
- R8: Writing the base or mask of a window whose enable bit is set raises `reg_err_o`. The new value is stored and reads back, but decoding keeps the values captured at the last 0-to-1 transition of that enable bit.
- R9: A write to an undefined index (6 and above) raises `reg_err_o`, changes no register, and reads of such an index return zero.
- R10: When enabled windows overlap, MMIO0 wins over MMIO1, which wins over the register window. `lkp_hit_o` has at most one bit set: bit 0 for MMIO0, bit 1 for MMIO1, bit 2 for the register window.
- R11: A lookup sampled on a clock edge reports `lkp_vld_o`, `lkp_hit_o` and `lkp_off_o` after that edge. A disabled window never hits. `lkp_hit_o` is zero whenever `lkp_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_be_i | input | 8 | Byte enables; all must be set |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, combinational during a legal read |
| reg_err_o | output | 1 | One-cycle error pulse for a rejected or locked access |
| lkp_vld_i | input | 1 | Lookup request |
| lkp_addr_i | input | 50 | System address to decode |
| lkp_vld_o | output | 1 | Lookup result valid |
| lkp_hit_o | output | 3 | One-hot winning window |
| lkp_off_o | output | 50 | Offset inside the winning window |

## Verification
A register write and an address lookup can land on the same clock edge. Two cases matter:
- A lookup that shares its edge with a locked base rewrite must still decode against the old snapshot.
- A lookup that shares its edge with an enable write must still see the window closed.

The bench forks the write task and the lookup task so that both drive inputs in the same cycle. The scoreboard then compares the decoded result with the window state that existed before the write.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int unsigned IDX_MBASE0 = 0;
  localparam int unsigned IDX_MBASE1 = 1;
  localparam int unsigned IDX_MMASK0 = 2;
  localparam int unsigned IDX_MMASK1 = 3;
  localparam int unsigned IDX_RBASE  = 4;
  localparam int unsigned IDX_EN     = 5;
  localparam int unsigned NUM_MMIO   = 2;
  localparam int unsigned NUM_WIN    = 3;
endpackage

// File: rtl/bwd_regs.sv
module bwd_regs #(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned SHIFT     = 14,
  parameter int unsigned RADDR_W   = 8,
  parameter int unsigned MMIO_LSB  = 30,
  parameter int unsigned RWIN_LSB  = 26,
  parameter int unsigned EN_LSB    = 59,
  parameter logic [REG_W-1:0] MBASE0_RST = 64'h3d00000000000 << 14,
  parameter logic [REG_W-1:0] MBASE1_RST = 64'h3ff8000000000 << 14,
  parameter logic [REG_W-1:0] MMASK0_RST = 64'h3fff000000000 << 14,
  parameter logic [REG_W-1:0] MMASK1_RST = 64'h3ffff80000000 << 14,
  parameter logic [REG_W-1:0] RBASE_RST  = 64'h3fffe40000000 << 14,
  localparam int unsigned AW    = REG_W - SHIFT,
  localparam int unsigned IDX_W = RADDR_W - 3,
  localparam int unsigned NWIN  = bwd_pkg::NUM_WIN,
  localparam int unsigned NMMIO = bwd_pkg::NUM_MMIO
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [RADDR_W-1:0]        addr_i,
  input  logic [7:0]                be_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic                      err_o,
  output logic [NWIN-1:0][AW-1:0]   win_base_o,
  output logic [NMMIO-1:0][AW-1:0]  mmio_mask_o,
  output logic [NWIN-1:0]           win_en_o
);
  import bwd_pkg::*;

  localparam logic [REG_W-1:0] MMIO_KEEP = {REG_W{1'b1}} << MMIO_LSB;
  localparam logic [REG_W-1:0] RWIN_KEEP = {REG_W{1'b1}} << RWIN_LSB;
  localparam logic [REG_W-1:0] EN_KEEP   = {REG_W{1'b1}} << EN_LSB;

  logic [NMMIO-1:0][REG_W-1:0] mbase_q, mmask_q;
  logic [REG_W-1:0]            rbase_q, en_q;
  logic [IDX_W-1:0]            idx;
  logic                        legal, known, locked, wr_ok, err_d;

  assign idx   = addr_i[RADDR_W-1:3];
  assign legal = (addr_i[2:0] == 3'b000) && (&be_i);

  always_comb begin
    known  = 1'b1;
    locked = 1'b0;
    unique case (idx)
      IDX_W'(IDX_MBASE0), IDX_W'(IDX_MMASK0): locked = en_q[REG_W-1];
      IDX_W'(IDX_MBASE1), IDX_W'(IDX_MMASK1): locked = en_q[REG_W-2];
      IDX_W'(IDX_RBASE):                      locked = en_q[REG_W-3];
      IDX_W'(IDX_EN):                         locked = 1'b0;
      default:                                known  = 1'b0;
    endcase
  end

  assign wr_ok = req_i && we_i && legal && known;
  assign err_d = req_i && (!legal || (we_i && (!known || locked)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbase_q[0] <= MBASE0_RST & MMIO_KEEP;
      mbase_q[1] <= MBASE1_RST & MMIO_KEEP;
      mmask_q[0] <= MMASK0_RST & MMIO_KEEP;
      mmask_q[1] <= MMASK1_RST & MMIO_KEEP;
      rbase_q    <= RBASE_RST & RWIN_KEEP;
      en_q       <= '0;
      err_o      <= 1'b0;
    end else begin
      err_o <= err_d;
      if (wr_ok) begin
        unique case (idx)
          IDX_W'(IDX_MBASE0): mbase_q[0] <= wdata_i & MMIO_KEEP;
          IDX_W'(IDX_MBASE1): mbase_q[1] <= wdata_i & MMIO_KEEP;
          IDX_W'(IDX_MMASK0): mmask_q[0] <= wdata_i & MMIO_KEEP;
          IDX_W'(IDX_MMASK1): mmask_q[1] <= wdata_i & MMIO_KEEP;
          IDX_W'(IDX_RBASE):  rbase_q    <= wdata_i & RWIN_KEEP;
          IDX_W'(IDX_EN):     en_q       <= wdata_i & EN_KEEP;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && legal) begin
      unique case (idx)
        IDX_W'(IDX_MBASE0): rdata_o = mbase_q[0];
        IDX_W'(IDX_MBASE1): rdata_o = mbase_q[1];
        IDX_W'(IDX_MMASK0): rdata_o = mmask_q[0];
        IDX_W'(IDX_MMASK1): rdata_o = mmask_q[1];
        IDX_W'(IDX_RBASE):  rdata_o = rbase_q;
        IDX_W'(IDX_EN):     rdata_o = en_q;
        default:            rdata_o = '0;
      endcase
    end
  end

  generate
    for (genvar m = 0; m < NMMIO; m++) begin : g_mmio_out
      assign win_base_o[m]  = mbase_q[m][REG_W-1:SHIFT];
      assign mmio_mask_o[m] = mmask_q[m][REG_W-1:SHIFT];
    end
  endgenerate
  assign win_base_o[NWIN-1] = rbase_q[REG_W-1:SHIFT];

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_en_out
      assign win_en_o[w] = en_q[REG_W-1-w];
    end
  endgenerate

  logic [6*REG_W-1:0] all_regs;
  assign all_regs = {mbase_q, mmask_q, rbase_q, en_q};

  // R1
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !legal) |=> ($stable(all_regs) && err_o))
    else $error("illegal access altered registers");

  // R9
  undef_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && legal && !known) |=> ($stable(all_regs) && err_o))
    else $error("undefined index write altered registers");

  // R8
  locked_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && legal && known && locked) |=> err_o)
    else $error("locked write without error");

  // R4
  en_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q & ~EN_KEEP) == '0)
    else $error("enable register holds bits outside its field");
endmodule

// File: rtl/bwd_window.sv
module bwd_window #(
  parameter int unsigned AW = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW:0]   size_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] off_o
);
  logic          en_q;
  logic [AW-1:0] base_q;
  logic [AW:0]   size_q;
  logic [AW:0]   diff;

  // snapshot on the 0->1 edge of the enable bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      size_q <= '0;
    end else begin
      en_q <= en_i;
      if (en_i && !en_q) begin
        base_q <= base_i;
        size_q <= size_i;
      end
    end
  end

  assign diff  = {1'b0, addr_i} - {1'b0, base_q};
  assign hit_o = en_i && en_q && !diff[AW] && (diff < size_q);
  assign off_o = diff[AW-1:0];

  // R8
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q) |=> ($stable(base_q) && $stable(size_q)))
    else $error("window snapshot changed while enabled");

  // R11
  dis_nohit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !hit_o)
    else $error("disabled window hit");
endmodule

// File: rtl/bwd_prio.sv
module bwd_prio #(
  parameter int unsigned NWIN = 3,
  parameter int unsigned AW   = 50
) (
  input  logic [NWIN-1:0]         hit_i,
  input  logic [NWIN-1:0][AW-1:0] off_i,
  output logic [NWIN-1:0]         sel_o,
  output logic [AW-1:0]           off_o
);
  // lowest index wins
  always_comb begin
    sel_o = '0;
    off_o = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel_o    = '0;
        sel_o[i] = 1'b1;
        off_o    = off_i[i];
      end
    end
  end
endmodule

// File: rtl/bar_window_dec.sv
module bar_window_dec #(
  parameter int unsigned REG_W     = 64,
  parameter int unsigned SHIFT     = 14,
  parameter int unsigned RADDR_W   = 8,
  parameter int unsigned RWIN_SIZE = 4096,
  localparam int unsigned AW   = REG_W - SHIFT,
  localparam int unsigned NWIN = bwd_pkg::NUM_WIN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [RADDR_W-1:0] reg_addr_i,
  input  logic [7:0]         reg_be_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               reg_err_o,
  input  logic               lkp_vld_i,
  input  logic [AW-1:0]      lkp_addr_i,
  output logic               lkp_vld_o,
  output logic [NWIN-1:0]    lkp_hit_o,
  output logic [AW-1:0]      lkp_off_o
);
  localparam int unsigned NMMIO = bwd_pkg::NUM_MMIO;

  logic [NWIN-1:0][AW-1:0]  win_base, win_off;
  logic [NMMIO-1:0][AW-1:0] mmio_mask;
  logic [NWIN-1:0][AW:0]    win_size;
  logic [NWIN-1:0]          win_en, win_hit, sel;
  logic [AW-1:0]            sel_off;

  bwd_regs #(.REG_W(REG_W), .SHIFT(SHIFT), .RADDR_W(RADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (reg_req_i),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .be_i        (reg_be_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .err_o       (reg_err_o),
    .win_base_o  (win_base),
    .mmio_mask_o (mmio_mask),
    .win_en_o    (win_en)
  );

  generate
    for (genvar g = 0; g < NWIN; g++) begin : g_win
      if (g < NMMIO) begin : g_mmio
        assign win_size[g] = {1'b0, ~mmio_mask[g]} + 1'b1;
      end else begin : g_fixed
        assign win_size[g] = (AW+1)'(RWIN_SIZE);
      end
      bwd_window #(.AW(AW)) u_win (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (win_en[g]),
        .base_i (win_base[g]),
        .size_i (win_size[g]),
        .addr_i (lkp_addr_i),
        .hit_o  (win_hit[g]),
        .off_o  (win_off[g])
      );
    end
  endgenerate

  bwd_prio #(.NWIN(NWIN), .AW(AW)) u_prio (
    .hit_i (win_hit),
    .off_i (win_off),
    .sel_o (sel),
    .off_o (sel_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_vld_o <= 1'b0;
      lkp_hit_o <= '0;
      lkp_off_o <= '0;
    end else begin
      lkp_vld_o <= lkp_vld_i;
      lkp_hit_o <= lkp_vld_i ? sel : '0;
      lkp_off_o <= lkp_vld_i ? sel_off : '0;
    end
  end

  // R10
  hit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_hit_o))
    else $error("more than one window reported");

  // R10
  prio_mmio0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_vld_i && win_hit[0]) |=> lkp_hit_o[0])
    else $error("MMIO0 lost priority");

  // R11
  idle_nohit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_vld_o |-> (lkp_hit_o == '0))
    else $error("hit without valid lookup");
endmodule

// File: tb/bar_window_dec_tb_top.sv
`timescale 1ns/1ps
module bar_window_dec_tb_top;
  localparam int AW = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_req = 1'b0, reg_we = 1'b0;
  logic [7:0]    reg_addr = '0, reg_be = '0;
  logic [63:0]   reg_wdata = '0, reg_rdata;
  logic          reg_err;
  logic          lkp_vld = 1'b0;
  logic [AW-1:0] lkp_addr = '0;
  logic          lkp_vld_o;
  logic [2:0]    lkp_hit;
  logic [AW-1:0] lkp_off;

  int n_vec = 0, n_bad = 0, n_issued = 0, n_seen = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]    hit;
    logic [AW-1:0] off;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  bar_window_dec dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_be_i(reg_be), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .reg_err_o(reg_err), .lkp_vld_i(lkp_vld), .lkp_addr_i(lkp_addr),
    .lkp_vld_o(lkp_vld_o), .lkp_hit_o(lkp_hit), .lkp_off_o(lkp_off)
  );

  function automatic logic [63:0] breg(input logic [AW-1:0] eff);
    return {eff, 14'b0};
  endfunction
  function automatic logic [63:0] mreg(input logic [AW-1:0] sz);
    return {~(sz - 1'b1), 14'b0};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic [7:0] be,
                    input logic exp_err, input string tag);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
    check({tag, " err"}, 64'(reg_err), 64'(exp_err));
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a; reg_be = 8'hFF;
    #1;
    check({tag, " rdata"}, reg_rdata, exp);
    @(negedge clk);
    reg_req = 1'b0;
  endtask

  task automatic lkp(input logic [AW-1:0] a, input logic [2:0] h,
                     input logic [AW-1:0] o, input string tag);
    exp_t e;
    e.hit = h; e.off = (h == 3'b000) ? '0 : o; e.tag = tag;
    exp_q.push_back(e);
    n_issued++;
    lkp_vld = 1'b1; lkp_addr = a;
    @(negedge clk);
    lkp_vld = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && lkp_vld_o) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        check("R11 unexpected result", 64'(lkp_hit), 64'hDEAD);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " hit"}, 64'(lkp_hit), 64'(e.hit));
        check({e.tag, " off"}, 64'(lkp_off), 64'(e.off));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 reset values
    rd(8'h00, 64'h3d00000000000 << 14, "R5 mbase0");
    rd(8'h08, 64'h3ff8000000000 << 14, "R5 mbase1");
    rd(8'h10, 64'h3fff000000000 << 14, "R5 mmask0");
    rd(8'h18, 64'h3ffff80000000 << 14, "R5 mmask1");
    rd(8'h20, 64'h3fffe40000000 << 14, "R5 rbase");
    rd(8'h28, 64'h0, "R5 enable");
    check("R11 idle vld", 64'(lkp_vld_o), 64'h0);

    // R2 / R3 field trimming
    wr(8'h00, '1, 8'hFF, 1'b0, "R2 mbase0");
    rd(8'h00, 64'hFFFF_FFFF_C000_0000, "R2 mbase0");
    wr(8'h18, '1, 8'hFF, 1'b0, "R2 mmask1");
    rd(8'h18, 64'hFFFF_FFFF_C000_0000, "R2 mmask1");
    wr(8'h20, '1, 8'hFF, 1'b0, "R3 rbase");
    rd(8'h20, 64'hFFFF_FFFF_FC00_0000, "R3 rbase");

    // program windows
    wr(8'h00, breg(50'h10_0000), 8'hFF, 1'b0, "R6 mbase0");
    wr(8'h10, mreg(50'h1_0000),  8'hFF, 1'b0, "R6 mmask0");
    wr(8'h08, breg(50'h10_0000), 8'hFF, 1'b0, "R6 mbase1");
    wr(8'h18, mreg(50'h4_0000),  8'hFF, 1'b0, "R6 mmask1");
    wr(8'h20, breg(50'h12_0000), 8'hFF, 1'b0, "R7 rbase");
    rd(8'h10, mreg(50'h1_0000), "R2 mmask0");

    // all disabled: no hits
    lkp(50'h10_0000, 3'b000, 0, "R11 disabled");

    // R4 enable all
    wr(8'h28, '1, 8'hFF, 1'b0, "R4 enable");
    rd(8'h28, 64'hF800_0000_0000_0000, "R4 enable");

    // R6 / R10 lookups, back to back
    lkp(50'h0F_FFFF, 3'b000, 0,            "R6 below base");
    lkp(50'h10_0000, 3'b001, 50'h0,        "R10 mmio0 over mmio1");
    lkp(50'h10_FFFF, 3'b001, 50'hFFFF,     "R6 mmio0 top");
    lkp(50'h11_0000, 3'b010, 50'h1_0000,   "R6 mmio1 past mmio0");
    lkp(50'h12_0004, 3'b010, 50'h2_0004,   "R10 mmio1 over rwin");
    lkp(50'h13_FFFF, 3'b010, 50'h3_FFFF,   "R6 mmio1 top");
    lkp(50'h14_0000, 3'b000, 0,            "R6 mmio1 end");
    @(negedge clk);

    // R8 locked base rewrite, concurrent lookup sees old snapshot
    fork
      wr(8'h00, breg(50'h30_0000), 8'hFF, 1'b1, "R8 locked mbase0");
      lkp(50'h10_0004, 3'b001, 50'h4, "R8 same-cycle old base");
    join
    rd(8'h00, breg(50'h30_0000), "R8 stored");
    lkp(50'h10_0008, 3'b001, 50'h8, "R8 snapshot kept");
    wr(8'h18, mreg(50'h1000), 8'hFF, 1'b1, "R8 locked mmask1");

    // mmio1 only; mmio1 stays enabled so snapshot is unchanged
    wr(8'h28, 64'h4000_0000_0000_0000, 8'hFF, 1'b0, "R4 mmio1 only");
    lkp(50'h10_0000, 3'b010, 50'h0,     "R4 mmio1 alone");
    lkp(50'h12_0004, 3'b010, 50'h2_0004, "R8 mmio1 old size");

    // register window only
    wr(8'h28, 64'h2000_0000_0000_0000, 8'hFF, 1'b0, "R4 rwin only");
    lkp(50'h12_0FFF, 3'b100, 50'hFFF, "R7 rwin top");
    lkp(50'h12_1000, 3'b000, 0,       "R7 rwin end");
    lkp(50'h11_FFFF, 3'b000, 0,       "R7 rwin below");
    lkp(50'h10_0000, 3'b000, 0,       "R11 mmio disabled");

    // re-enable mmio0: concurrent lookup still closed, later new snapshot
    fork
      wr(8'h28, 64'h8000_0000_0000_0000, 8'hFF, 1'b0, "R8 re-enable");
      lkp(50'h30_0004, 3'b000, 0, "R11 same-cycle enable");
    join
    lkp(50'h30_0004, 3'b001, 50'h4, "R8 new snapshot");
    lkp(50'h10_0000, 3'b000, 0,     "R8 old base gone");

    // R1 illegal accesses
    wr(8'h00, breg(50'h50_0000), 8'h0F, 1'b1, "R1 partial be");
    wr(8'h03, breg(50'h50_0000), 8'hFF, 1'b1, "R1 misaligned");
    rd(8'h00, breg(50'h30_0000), "R1 unchanged");

    // R9 undefined index
    wr(8'h30, '1, 8'hFF, 1'b1, "R9 undefined");
    rd(8'h30, 64'h0, "R9 read zero");
    rd(8'h28, 64'h8000_0000_0000_0000, "R9 enable unchanged");
    wr(8'h28, 64'h0, 8'hFF, 1'b0, "R4 disable");

    repeat (3) @(negedge clk);
    check("R11 result count", 64'(n_seen), 64'(n_issued));
    check("R11 idle hit", 64'(lkp_hit), 64'h0);
    finish_run();
  end
endmodule